// File: doc/BRIEF.md
# Page Register Serial Read Pointer

This block holds the column pointer that walks through a 264-byte page register while its contents are streamed out one byte per read strobe. The page splits into a 256-byte main region (bytes 0 to 255) and an 8-byte spare region (bytes 256 to 263). A read-mode command picks the region. A column address byte loads the start point. Each read strobe registers the addressed byte onto the output bus and moves the pointer forward by one. At the last byte the pointer stops, so every further strobe returns that byte again.

The region choice is sticky. Once the spare region is chosen, later address loads stay inside it until the main-region command is given. A status command redirects strobes to an external status byte and holds the pointer. A later main-region command picks up the data stream from the held pointer, with no new address. The page register itself is filled through a plain write port, which stands in for the array-to-register transfer.

Top module: `page_read_ptr`

## Requirements
- R1: After reset the pointer is 0, the main region is selected, data mode is active (not status) and the output byte is 0x00.
- R2: Command 0x00 selects the main region. A column address byte C then sets the pointer to C (0 to 255).
- R3: Command 0x50 selects the spare region. A column address byte then sets the pointer to 256 plus its three low bits, and its five high bits are ignored.
- R4: While the spare region is selected, every address load stays in 256 to 263, even after page register rewrites. No address load leaves the spare region; only command 0x00 or 0xFF does.
- R5: A read strobe in data mode registers the byte at the pointer onto the output, visible one clock later, and advances the pointer by one.
- R6: In the main region a run of strobes crosses from byte 255 into bytes 256 to 263 without stopping.
- R7: At pointer 263 a strobe outputs byte 263 again and the pointer stays at 263.
- R8: Command 0x70 enters status mode. In status mode a strobe outputs the status input byte and leaves the pointer unchanged.
- R9: Command 0x00 given in status mode returns to data mode. The next strobe outputs the byte at the held pointer, with no address load.
- R10: Command 0xFF sets the pointer to 0, selects the main region and leaves status mode, from any state.
- R11: Any command code other than 0x00, 0x50, 0x70 and 0xFF changes nothing.
- R12: In one cycle a command wins over an address load, and an address load wins over a strobe; the losing input is dropped. A strobe and a page register write to the same byte in one cycle output the old byte.
- R13: Command 0x50 issued while the main region is selected moves the pointer to 256. Command 0x00 issued while the spare region is selected moves the pointer to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command byte present this cycle |
| cmd_code | input | 8 | Command byte |
| addr_valid | input | 1 | Column address byte present this cycle |
| col_addr | input | 8 | Column address byte |
| rd_stb | input | 1 | Read strobe, one pulse per byte |
| buf_we | input | 1 | Page register write enable |
| buf_idx | input | 9 | Page register write index |
| buf_wdata | input | 8 | Page register write data |
| status_in | input | 8 | Status byte returned in status mode |
| rd_data | output | 8 | Registered output byte |
| rd_ptr | output | 9 | Current pointer |
| spare_sel | output | 1 | Spare region selected |
| status_mode | output | 1 | Status mode active |

## Verification
Two pairs of events can land in the same cycle. A strobe can arrive together with a command or an address byte, and a strobe can arrive together with a page register write to the byte being read. The bench drives these pairs on purpose. In the first case the output byte must stay at its previous value and the pointer must take the value the winning input gives. In the second case the scoreboard expects the old byte and then reads the new byte back after reloading the same column.

// File: rtl/page_read_ptr.sv
module page_read_ptr #(
  parameter int DW          = 8,
  parameter int MAIN_BYTES  = 256,
  parameter int SPARE_BYTES = 8,
  parameter logic [7:0] CMD_MAIN  = 8'h00,
  parameter logic [7:0] CMD_SPARE = 8'h50,
  parameter logic [7:0] CMD_STAT  = 8'h70,
  parameter logic [7:0] CMD_RST   = 8'hFF,
  localparam int TOTAL = MAIN_BYTES + SPARE_BYTES,
  localparam int PW    = $clog2(TOTAL),
  localparam int CW    = $clog2(MAIN_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [7:0]    cmd_code,
  input  logic          addr_valid,
  input  logic [CW-1:0] col_addr,
  input  logic          rd_stb,
  input  logic          buf_we,
  input  logic [PW-1:0] buf_idx,
  input  logic [DW-1:0] buf_wdata,
  input  logic [DW-1:0] status_in,
  output logic [DW-1:0] rd_data,
  output logic [PW-1:0] rd_ptr,
  output logic          spare_sel,
  output logic          status_mode
);
  localparam int SW = $clog2(SPARE_BYTES);
  localparam logic [PW-1:0] LAST       = PW'(TOTAL - 1);
  localparam logic [PW-1:0] SPARE_BASE = PW'(MAIN_BYTES);

  logic [DW-1:0] page [TOTAL];

  always_ff @(posedge clk)
    if (buf_we && (int'(buf_idx) < TOTAL)) page[buf_idx] <= buf_wdata;

  wire c_rst   = cmd_valid && cmd_code == CMD_RST;
  wire c_main  = cmd_valid && cmd_code == CMD_MAIN;
  wire c_spare = cmd_valid && cmd_code == CMD_SPARE;
  wire c_stat  = cmd_valid && cmd_code == CMD_STAT;
  wire do_addr = addr_valid && !cmd_valid;
  wire do_rd   = rd_stb && !cmd_valid && !addr_valid;

  wire [PW-1:0] load_ptr = spare_sel ? SPARE_BASE + PW'(col_addr[SW-1:0])
                                     : PW'(col_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr      <= '0;
      spare_sel   <= 1'b0;
      status_mode <= 1'b0;
      rd_data     <= '0;
    end else if (c_rst) begin
      rd_ptr      <= '0;
      spare_sel   <= 1'b0;
      status_mode <= 1'b0;
    end else if (c_main) begin
      status_mode <= 1'b0;
      spare_sel   <= 1'b0;
      if (spare_sel) rd_ptr <= '0;
    end else if (c_spare) begin
      status_mode <= 1'b0;
      spare_sel   <= 1'b1;
      if (!spare_sel) rd_ptr <= SPARE_BASE;
    end else if (c_stat) begin
      status_mode <= 1'b1;
    end else if (do_addr) begin
      rd_ptr <= load_ptr;
    end else if (do_rd) begin
      rd_data <= status_mode ? status_in : page[rd_ptr];
      if (!status_mode && rd_ptr != LAST) rd_ptr <= rd_ptr + 1'b1;
    end
  end
endmodule

// File: rtl/page_read_ptr_chk.sv
module page_read_ptr_chk #(
  parameter int DW          = 8,
  parameter int MAIN_BYTES  = 256,
  parameter int SPARE_BYTES = 8,
  localparam int TOTAL = MAIN_BYTES + SPARE_BYTES,
  localparam int PW    = $clog2(TOTAL),
  localparam int CW    = $clog2(MAIN_BYTES)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic [7:0]    cmd_code,
  input logic          addr_valid,
  input logic [CW-1:0] col_addr,
  input logic          rd_stb,
  input logic          buf_we,
  input logic [PW-1:0] buf_idx,
  input logic [DW-1:0] buf_wdata,
  input logic [DW-1:0] status_in,
  input logic [DW-1:0] rd_data,
  input logic [PW-1:0] rd_ptr,
  input logic          spare_sel,
  input logic          status_mode
);
  localparam logic [PW-1:0] LAST = PW'(TOTAL - 1);
  wire strobe = rd_stb && !cmd_valid && !addr_valid;
  wire known = cmd_code == 8'h00 || cmd_code == 8'h50 || cmd_code == 8'h70 || cmd_code == 8'hFF;

  // R7
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !status_mode && rd_ptr == LAST) |=> rd_ptr == LAST);
  // R5
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !status_mode && rd_ptr != LAST) |=> rd_ptr == $past(rd_ptr) + PW'(1));
  // R4
  spare_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spare_sel |-> rd_ptr >= PW'(MAIN_BYTES));
  // R8
  stat_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && status_mode) |=> (rd_data == $past(status_in) && $stable(rd_ptr)));
  // R10
  rst_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == 8'hFF) |=> (rd_ptr == '0 && !spare_sel && !status_mode));
  // R11
  unknown_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !known) |=> ($stable(rd_ptr) && $stable(spare_sel) && $stable(status_mode)));
endmodule

bind page_read_ptr page_read_ptr_chk #(.DW(DW), .MAIN_BYTES(MAIN_BYTES), .SPARE_BYTES(SPARE_BYTES)) u_chk (.*);

// File: tb/tb_page_read_ptr.sv
`timescale 1ns/1ps
module tb_page_read_ptr;
  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, addr_valid = 0, rd_stb = 0, buf_we = 0;
  logic [7:0] cmd_code = 0, col_addr = 0, buf_wdata = 0, status_in = 0;
  logic [8:0] buf_idx = 0;
  logic [7:0] rd_data;
  logic [8:0] rd_ptr;
  logic spare_sel, status_mode;

  page_read_ptr dut (.*);

  always #10 clk = ~clk;

  int checks = 0, failures = 0;
  logic [7:0] m [264];
  logic [7:0] exp_q [$];
  string tag_q [$];
  bit done = 0;

  always @(negedge clk) if (exp_q.size() > 0) begin
    automatic logic [7:0] e = exp_q.pop_front();
    automatic string t = tag_q.pop_front();
    checks++;
    if (rd_data !== e) begin
      failures++;
      $display("FAIL %s rd_data actual=%02h expected=%02h", t, rd_data, e);
    end
  end

  task automatic chk(int act, int expv, string tag);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic step(bit cv, logic [7:0] c, bit av, logic [7:0] a, bit rv,
                      bit we, int idx, logic [7:0] d, bit push, logic [7:0] e, string tag);
    cmd_valid = cv; cmd_code = c; addr_valid = av; col_addr = a; rd_stb = rv;
    buf_we = we; buf_idx = 9'(idx); buf_wdata = d;
    @(posedge clk);
    if (push) begin exp_q.push_back(e); tag_q.push_back(tag); end
    @(negedge clk);
    cmd_valid = 0; addr_valid = 0; rd_stb = 0; buf_we = 0;
  endtask

  task automatic do_cmd(logic [7:0] c); step(1, c, 0, 0, 0, 0, 0, 0, 0, 0, ""); endtask
  task automatic do_addr(logic [7:0] a); step(0, 0, 1, a, 0, 0, 0, 0, 0, 0, ""); endtask
  task automatic do_rd(logic [7:0] e, string tag); step(0, 0, 0, 0, 1, 0, 0, 0, 1, e, tag); endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(rd_ptr, 0, "R1 ptr"); chk(spare_sel, 0, "R1 region");
    chk(status_mode, 0, "R1 mode"); chk(rd_data, 0, "R1 data");
    for (int i = 0; i < 264; i++) begin
      m[i] = (i < 256) ? 8'((i * 7 + 3) & 255) : 8'(8'hA0 + i - 256);
      step(0, 0, 0, 0, 0, 1, i, m[i], 0, 0, "");
    end
    do_cmd(8'h00); do_addr(8'h10);
    chk(rd_ptr, 16, "R2 load");
    for (int i = 16; i < 19; i++) do_rd(m[i], "R5 byte");
    chk(rd_ptr, 19, "R5 advance");
    do_addr(8'hFF); chk(rd_ptr, 255, "R2 top");
    do_addr(8'hFE);
    for (int i = 254; i < 259; i++) do_rd(m[i], "R6 cross");
    chk(rd_ptr, 259, "R6 ptr");
    do_cmd(8'h00); do_cmd(8'h50);
    chk(rd_ptr, 256, "R13 to spare"); chk(spare_sel, 1, "R3 region");
    do_addr(8'hFD); chk(rd_ptr, 261, "R3 low bits");
    do_rd(m[261], "R7 run"); do_rd(m[262], "R7 run");
    do_rd(m[263], "R7 last"); do_rd(m[263], "R7 repeat");
    chk(rd_ptr, 263, "R7 hold");
    do_addr(8'h02); chk(rd_ptr, 258, "R4 sticky");
    do_cmd(8'h00); chk(rd_ptr, 0, "R13 to main"); chk(spare_sel, 0, "R4 exit");
    do_addr(8'h20); do_rd(m[32], "R5 byte"); do_rd(m[33], "R5 byte");
    status_in = 8'hC0;
    do_cmd(8'h70); chk(status_mode, 1, "R8 enter");
    do_rd(8'hC0, "R8 status"); do_rd(8'hC0, "R8 status");
    chk(rd_ptr, 34, "R8 held");
    do_cmd(8'h00); chk(status_mode, 0, "R9 exit");
    do_rd(m[34], "R9 resume");
    do_cmd(8'h90);
    chk(rd_ptr, 35, "R11 ptr"); chk(status_mode, 0, "R11 mode"); chk(spare_sel, 0, "R11 region");
    do_rd(m[35], "R11 data");
    step(1, 8'h70, 0, 0, 1, 0, 0, 0, 0, 0, "");
    chk(rd_ptr, 36, "R12 cmd wins"); chk(status_mode, 1, "R12 cmd wins");
    chk(rd_data, m[35], "R12 rd dropped");
    do_cmd(8'h00);
    step(0, 0, 1, 8'h40, 1, 0, 0, 0, 0, 0, "");
    chk(rd_ptr, 64, "R12 addr wins"); chk(rd_data, m[35], "R12 rd dropped");
    step(0, 0, 0, 0, 1, 1, 64, 8'h5A, 1, m[64], "R12 old byte");
    m[64] = 8'h5A;
    do_addr(8'h40); do_rd(8'h5A, "R12 new byte");
    do_cmd(8'h50); do_addr(8'h01); chk(rd_ptr, 257, "R3 load");
    do_cmd(8'h70); do_cmd(8'hFF);
    chk(rd_ptr, 0, "R10 ptr"); chk(spare_sel, 0, "R10 region"); chk(status_mode, 0, "R10 mode");
    do_cmd(8'h50); do_addr(8'h07); do_rd(m[263], "R4 spare");
    m[256] = 8'h3C;
    step(0, 0, 0, 0, 0, 1, 256, 8'h3C, 0, 0, "");
    do_addr(8'hF8); chk(rd_ptr, 256, "R3 high ignored"); chk(spare_sel, 1, "R4 kept");
    do_rd(8'h3C, "R4 reload");
    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule